// File: doc/BRIEF.md
# Audio Clock Regeneration CTS Scheduler

This block picks the cycle time stamp (CTS) value that goes with each audio clock regeneration packet of a digital video transmitter. Software programs a 20-bit N, two 20-bit CTS values and two 20-bit dwell counts. The block counts events and uses the first CTS value for its dwell count, then the second for its own, and repeats. The long-run average CTS can therefore sit between two integers. A configuration bit selects what counts as an event: a pixel-clock enable or a sync strobe from the audio bus. Each time a dwell completes, the block offers one packet request carrying N and the CTS value that just finished its dwell. The request goes out on a valid/ready interface to the packet serializer.

An external-CTS mode replaces the programmed values with a CTS measured elsewhere, supplied on an input. A disable bit stops all requests and returns the scheduler to its starting point. The request interface follows the usual valid/ready rules. Once `pkt_valid` rises, it stays high with `pkt_n` and `pkt_cts` unchanged until a cycle in which `pkt_ready` is high. A dwell that completes while a request is still waiting produces no request, but the alternation advances as usual.

Top module: `acr_cts_sched`

## Requirements
- R1: After reset `pkt_valid` is low, the configuration register reads as all zero, and the scheduler stands on the first CTS value with no events counted.
- R2: A write with `wr_en` high updates one register at the next clock edge, chosen by `wr_addr`. The encodings are: 0 selects configuration (N in bits 19:0, external-CTS enable in bit 24, disable in bit 25, sync-event select in bit 26), 1 selects CTS value 0, 2 selects CTS value 1, 3 selects dwell count 0, and 4 selects dwell count 1. Data for the 20-bit registers sits in bits 19:0.
- R3: With bit 26 clear, only cycles with `pix_en` high count as events. With bit 26 set, only cycles with `sync_pulse` high count, and `pix_en` has no effect.
- R4: The scheduler uses CTS value 0 for dwell-count-0 events, then CTS value 1 for dwell-count-1 events, and repeats. The last event of each dwell offers a request carrying N and the CTS value of that dwell. `pkt_valid` becomes high in the cycle after the clock edge that samples that event.
- R5: A dwell count of zero behaves as a count of one.
- R6: While the disable bit is set, no request is offered, a pending request is withdrawn one cycle after the bit takes effect, and the scheduler returns to CTS value 0 with no events counted. When the bit clears, counting restarts from that state.
- R7: With external-CTS enabled, a request carries the `ext_cts` value present in the cycle of its final event. Its N has bits 6:0 forced to zero, so N is always a multiple of 128.
- R8: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_n` and `pkt_cts` stay unchanged. A dwell that completes during this wait offers no request, but the scheduler still switches to the other CTS value.
- R9: If a dwell completes in the same cycle that a pending request is accepted, the new request replaces it and `pkt_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| pix_en | input | 1 | Pixel-clock event enable |
| sync_pulse | input | 1 | Audio-bus sync event strobe |
| ext_cts | input | 20 | Externally measured CTS |
| pkt_valid | output | 1 | Packet request pending |
| pkt_ready | input | 1 | Serializer accepts the request |
| pkt_n | output | 20 | N carried by the request |
| pkt_cts | output | 20 | CTS carried by the request |

## Verification
Two events can collide in a single cycle: a completed dwell can load a new request in the same cycle that the serializer accepts the old one. The bench sets up this collision by holding `pkt_ready` low until a request is pending. It then raises `pkt_ready` in the same cycle as the event that ends the next dwell. The check passes only if `pkt_valid` stays high and the payload has changed to the next CTS value. A second case pairs a completed dwell with a request that is still waiting. That dwell must be dropped, and the bench judges this by which CTS value the next accepted request carries.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned BIT_EXT  = 24;
  localparam int unsigned BIT_DIS  = 25;
  localparam int unsigned BIT_SYNC = 26;

  typedef enum logic [2:0] {
    A_CFG  = 3'd0,
    A_CTS0 = 3'd1,
    A_CTS1 = 3'd2,
    A_PER0 = 3'd3,
    A_PER1 = 3'd4
  } acr_addr_e;
endpackage

// File: rtl/acr_cfg_regs.sv
module acr_cfg_regs
  import acr_pkg::*;
#(
  parameter int W  = 20,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [W-1:0]        n_val,
  output logic                ext_en,
  output logic                dis,
  output logic                sync_sel,
  output logic [1:0][W-1:0]   cts_pair,
  output logic [1:0][W-1:0]   per_pair
);
  logic [W-1:0] n_q;
  logic         ext_q, dis_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= '0;
      ext_q  <= 1'b0;
      dis_q  <= 1'b0;
      sync_q <= 1'b0;
    end else if (wr_en && wr_addr == AW'(A_CFG)) begin
      n_q    <= wr_data[W-1:0];
      ext_q  <= wr_data[BIT_EXT];
      dis_q  <= wr_data[BIT_DIS];
      sync_q <= wr_data[BIT_SYNC];
    end
  end

  // One CTS value and one dwell count per side of the alternation
  for (genvar i = 0; i < 2; i++) begin : g_side
    logic [W-1:0] cts_q, per_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cts_q <= '0;
        per_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(A_CTS0) + AW'(i)) cts_q <= wr_data[W-1:0];
        if (wr_addr == AW'(A_PER0) + AW'(i)) per_q <= wr_data[W-1:0];
      end
    end
    assign cts_pair[i] = cts_q;
    assign per_pair[i] = per_q;
  end

  assign n_val    = n_q;
  assign ext_en   = ext_q;
  assign dis      = dis_q;
  assign sync_sel = sync_q;
endmodule

// File: rtl/acr_dwell_ctr.sv
module acr_dwell_ctr #(
  parameter int W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev,
  input  logic [1:0][W-1:0] per_pair,
  output logic              roll,
  output logic              sel
);
  logic [W-1:0] cnt;
  logic [W-1:0] per_cur;
  logic [W-1:0] limit;

  assign per_cur = per_pair[sel];
  // zero dwell behaves as a single event
  assign limit   = (per_cur == '0) ? '0 : per_cur - W'(1);
  assign roll    = ev && !clr && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      sel <= 1'b0;
    end else if (ev) begin
      if (cnt >= limit) begin
        cnt <= '0;
        sel <= ~sel;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/acr_req_slot.sv
module acr_req_slot #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] n_in,
  input  logic [W-1:0] cts_in,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] n_out,
  output logic [W-1:0] cts_out
);
  logic take;
  assign take = load && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      valid   <= 1'b0;
      n_out   <= '0;
      cts_out <= '0;
    end else if (take) begin
      valid   <= 1'b1;
      n_out   <= n_in;
      cts_out <= cts_in;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/acr_cts_sched.sv
module acr_cts_sched #(
  parameter int W     = 20,
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int ALIGN = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pix_en,
  input  logic          sync_pulse,
  input  logic [W-1:0]  ext_cts,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [W-1:0]  pkt_n,
  output logic [W-1:0]  pkt_cts
);
  localparam logic [W-1:0] ALIGN_MASK = ~((W'(1) << ALIGN) - W'(1));

  logic [W-1:0]      n_val;
  logic              ext_en, dis, sync_sel;
  logic [1:0][W-1:0] cts_pair, per_pair;
  logic              ev, roll, sel;
  logic [W-1:0]      n_req, cts_req;

  acr_cfg_regs #(.W(W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .n_val(n_val), .ext_en(ext_en), .dis(dis), .sync_sel(sync_sel),
    .cts_pair(cts_pair), .per_pair(per_pair)
  );

  assign ev = sync_sel ? sync_pulse : pix_en;

  acr_dwell_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(dis), .ev(ev), .per_pair(per_pair),
    .roll(roll), .sel(sel)
  );

  assign cts_req = ext_en ? ext_cts : cts_pair[sel];
  assign n_req   = ext_en ? (n_val & ALIGN_MASK) : n_val;

  acr_req_slot #(.W(W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(dis), .load(roll), .n_in(n_req), .cts_in(cts_req),
    .ready(pkt_ready), .valid(pkt_valid), .n_out(pkt_n), .cts_out(pkt_cts)
  );
endmodule

// File: rtl/acr_cts_sched_chk.sv
module acr_cts_sched_chk #(
  parameter int W     = 20,
  parameter int ALIGN = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pkt_valid,
  input logic         pkt_ready,
  input logic [W-1:0] pkt_n,
  input logic [W-1:0] pkt_cts,
  input logic         roll,
  input logic         sel,
  input logic         dis,
  input logic         ext_en,
  input logic [W-1:0] cts0,
  input logic [W-1:0] cts1
);
  a_r1_req_from_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(roll));

  a_r4_programmed_cts: assert property (@(posedge clk) disable iff (!rst_n)
    roll && !ext_en && (!pkt_valid || pkt_ready) |=> pkt_cts == $past(sel ? cts1 : cts0));

  a_r6_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !pkt_valid);

  a_r7_n_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    roll && ext_en && (!pkt_valid || pkt_ready) |=> pkt_n[ALIGN-1:0] == '0);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready && !dis |=> pkt_valid && $stable(pkt_cts) && $stable(pkt_n));

  a_r9_replace_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    roll && pkt_valid && pkt_ready |=> pkt_valid);
endmodule

bind acr_cts_sched acr_cts_sched_chk #(.W(W), .ALIGN(ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_n(pkt_n), .pkt_cts(pkt_cts), .roll(roll), .sel(sel), .dis(dis),
  .ext_en(ext_en), .cts0(cts_pair[0]), .cts1(cts_pair[1])
);

// File: tb/acr_cts_sched_bench.sv
module acr_cts_sched_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_en = 1'b0;
  logic        sync_pulse = 1'b0;
  logic [19:0] ext_cts = '0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b1;
  logic [19:0] pkt_n, pkt_cts;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  acr_cts_sched u_acr_cts_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_en(pix_en), .sync_pulse(sync_pulse), .ext_cts(ext_cts),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_n(pkt_n), .pkt_cts(pkt_cts)
  );

  // bit positions per R2
  localparam logic [31:0] C_EXT  = 32'h1 << 24;
  localparam logic [31:0] C_DIS  = 32'h1 << 25;
  localparam logic [31:0] C_SYNC = 32'h1 << 26;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input logic p, input logic s);
    pix_en = p; sync_pulse = s;
    @(negedge clk);
    pix_en = 1'b0; sync_pulse = 1'b0;
  endtask

  task automatic chk(input logic ev, input logic [19:0] ec, input logic [19:0] en,
                     input string r);
    total++;
    if (pkt_valid !== ev || (ev && (pkt_cts !== ec || pkt_n !== en))) begin
      bad++;
      $display("FAIL %s: valid=%0b cts=%h n=%h expected valid=%0b cts=%h n=%h",
               r, pkt_valid, pkt_cts, pkt_n, ev, ec, en);
    end
  endtask

  task automatic restart(input logic [31:0] cfg);
    wr(3'd0, cfg | C_DIS);
    @(negedge clk);
    wr(3'd0, cfg);
  endtask

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] nv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, first dwell uses CTS value 0
    chk(1'b0, '0, '0, "R1 reset");
    wr(3'd1, 32'h00AAA); wr(3'd2, 32'h00BBB); wr(3'd3, 32'd2); wr(3'd4, 32'd1);
    wr(3'd0, 32'h01000);
    cyc(1, 0); chk(1'b0, '0, '0, "R1 first event");
    cyc(1, 0); chk(1'b1, 20'h00AAA, 20'h01000, "R1 first packet CTS0");

    // R2 R3 R4 R5: sweep dwell counts 0..3 on both event sources
    nv = 20'h01800;
    for (int m = 0; m < 2; m++) begin
      for (int p0 = 0; p0 < 4; p0++) begin
        for (int p1 = 0; p1 < 4; p1++) begin
          logic [19:0] c0, c1;
          logic [31:0] cfg;
          int cnt, ms;
          c0 = 20'h1A000 + 20'(p0 * 16 + p1);
          c1 = 20'h2B000 + 20'(p1 * 16 + p0);
          cfg = {12'h0, nv} | (m == 1 ? C_SYNC : 32'h0);
          wr(3'd0, cfg | C_DIS);
          wr(3'd1, {12'h0, c0}); wr(3'd2, {12'h0, c1});
          wr(3'd3, 32'(p0)); wr(3'd4, 32'(p1));
          wr(3'd0, cfg);
          cnt = 0; ms = 0;
          for (int e = 0; e < 10; e++) begin
            logic exp_v;
            logic [19:0] exp_c;
            // the other source must not count (R3)
            if (m == 1) begin
              cyc(1, 0); chk(1'b0, '0, '0, "R3 pix_en ignored in sync mode");
            end else begin
              cyc(0, 1); chk(1'b0, '0, '0, "R3 sync ignored in pixel mode");
            end
            cnt++;
            exp_v = 1'b0; exp_c = '0;
            if (cnt >= eff(ms == 0 ? p0 : p1)) begin
              exp_v = 1'b1; exp_c = (ms == 0) ? c0 : c1;
              ms ^= 1; cnt = 0;
            end
            if (m == 1) cyc(0, 1); else cyc(1, 0);
            chk(exp_v, exp_c, nv, (p0 == 0 || p1 == 0) ? "R5 zero dwell" : "R4 alternation");
          end
        end
      end
    end

    // R6: disable mid-dwell, then restart on CTS value 0
    wr(3'd1, 32'h00C0C); wr(3'd2, 32'h00D0D); wr(3'd3, 32'd3); wr(3'd4, 32'd3);
    restart(32'h00400);
    cyc(1, 0); cyc(1, 0);
    wr(3'd0, 32'h00400 | C_DIS);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0); chk(1'b0, '0, '0, "R6 disabled no request");
    end
    wr(3'd0, 32'h00400);
    cyc(1, 0); chk(1'b0, '0, '0, "R6 restart count");
    cyc(1, 0); chk(1'b0, '0, '0, "R6 restart count");
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00400, "R6 restart on CTS0");
    // R6: pending request withdrawn
    pkt_ready = 1'b0;
    wr(3'd3, 32'd1); wr(3'd4, 32'd1);
    restart(32'h00400);
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00400, "R6 pending before disable");
    wr(3'd0, 32'h00400 | C_DIS);
    cyc(0, 0); chk(1'b0, '0, '0, "R6 pending withdrawn");
    pkt_ready = 1'b1;

    // R7: external CTS and N alignment
    restart(C_EXT | 32'h12345);
    ext_cts = 20'hABCDE;
    cyc(1, 0); chk(1'b1, 20'hABCDE, 20'h12300, "R7 external CTS");
    ext_cts = 20'h55555;
    cyc(1, 0); chk(1'b1, 20'h55555, 20'h12300, "R7 external CTS follows input");

    // R8: back-pressure holds payload, completed dwells dropped
    restart(32'h00800);
    pkt_ready = 1'b0;
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00800, "R8 request pending");
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00800, "R8 held through drop");
    cyc(0, 0); chk(1'b1, 20'h00C0C, 20'h00800, "R8 held idle");
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00800, "R8 held through drop");
    pkt_ready = 1'b1;
    cyc(0, 0); chk(1'b0, '0, '0, "R8 accepted");
    cyc(1, 0); chk(1'b1, 20'h00D0D, 20'h00800, "R8 alternation advanced past drops");

    // R9: completion in the cycle of acceptance replaces the request
    restart(32'h00800);
    pkt_ready = 1'b0;
    cyc(1, 0); chk(1'b1, 20'h00C0C, 20'h00800, "R9 first pending");
    pkt_ready = 1'b1;
    cyc(1, 0); chk(1'b1, 20'h00D0D, 20'h00800, "R9 replaced while accepted");
    cyc(0, 0); chk(1'b0, '0, '0, "R9 drained");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule